// File: doc/BRIEF.md
# UART Banked Control Register File

This block is the software-visible control front end of a serial port. A host reaches it through a small synchronous slave bus that carries an address, write data, a write strobe, a read strobe and combinational read data. Eight shared addresses cover more registers than that, so the line-control value picks the register bank that the low addresses reach. In the operating bank they reach the interrupt-enable and modem-control registers. In the divisor bank they reach the two halves of the baud divisor. When the line-control value is exactly 0xBF, they reach an extension register.

Bit 4 of the extension register is a write guard. Until software sets it, writes to the interrupt-enable and modem-control registers are dropped. The block also holds a mode register whose low field value 7 holds the port disabled. Line-control bit 6 drives the break output. A self-clearing soft-reset request returns every register to its power-up value over a fixed number of cycles, and a status bit shows when the reset has finished. The decoded control values go out as ports to the serializer, the baud generator and the modem logic.

Top module: `uart_cfg_regbank`

## Requirements
- R1: After hardware reset, line control, interrupt enable, modem control, extension and both divisor bytes read 0x00. The mode register reads 0x07, so uart_disabled_o is 1. Status (address 7) reads 0x01.
- R2: The extension register (address 2) is reachable only while line control equals 0xBF. In any other state it reads 0x00 and writes to it are dropped. enh_en_o is its bit 4.
- R3: Interrupt enable (address 1) and modem control (address 4) are reachable only while line-control bit 7 is 0. In any other state address 4 reads 0x00 and writes to it are dropped.
- R4: A write to interrupt enable or modem control changes the register only if extension bit 4 is 1. Otherwise the register keeps its value.
- R5: While line-control bit 7 is 1 and the value is not 0xBF, address 0 holds the divisor low byte and address 1 holds the divisor high byte (divisor_o = {high, low}). In any other state address 0 reads 0x00 and writes to it are dropped.
- R6: break_o follows line-control bit 6 (address 3) from the cycle after the write.
- R7: mode_o is mode-register bits [2:0] (address 5). uart_disabled_o is 1 exactly when those bits are 3'b111, whatever the upper bits hold.
- R8: A write to address 6 with bit 1 set starts a soft reset. Address 6 always reads 0x00. Status bit 0 (address 7) reads 0 and srst_busy_o is 1 for the 4 cycles after the write, and both return after the 4th following clock edge.
- R9: When a soft reset ends, every register holds its R1 value. Bus writes made while the reset is running are dropped, and writes work normally again afterwards.
- R10: rdata_o is 0x00 whenever rd_en_i is 0. Line control (address 3) and the mode register (address 5) are reachable in every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, taken on the rising edge |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| lcr_o | output | 8 | Line-control value (frame format to serializer) |
| ier_o | output | 8 | Interrupt-enable value |
| mcr_o | output | 8 | Modem-control value |
| divisor_o | output | 16 | Baud divisor {high, low} |
| break_o | output | 1 | Force break on the line |
| enh_en_o | output | 1 | Extension write guard bit |
| mode_o | output | 3 | Operating mode field |
| uart_disabled_o | output | 1 | Port held disabled (mode field all ones) |
| srst_busy_o | output | 1 | Soft reset in progress |

## Verification
Two functions can act on the same cycle: the soft-reset clear and an ordinary bus write. To provoke the clash, the bench loads nonzero values into several registers, requests a soft reset, and writes a fresh value to interrupt enable while the reset is still running. It passes if that register, and every other, holds its power-up value once status bit 0 returns to 1. It also checks that the same write sequence made after the reset does take effect.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  // shared bus addresses
  localparam logic [ADDR_W-1:0] A_LOW     = 3'd0;
  localparam logic [ADDR_W-1:0] A_HIGH    = 3'd1;
  localparam logic [ADDR_W-1:0] A_EXT     = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE    = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODEM   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MODE    = 3'd5;
  localparam logic [ADDR_W-1:0] A_SYSCFG  = 3'd6;
  localparam logic [ADDR_W-1:0] A_SYSSTAT = 3'd7;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'hBF;
  localparam int GUARD_BIT  = 4;
  localparam int BREAK_BIT  = 6;
  localparam int BANK_BIT   = 7;
  localparam int SRST_BIT   = 1;
  localparam int MODE_W     = 3;

  // storage slots
  localparam int RI_DLO  = 0;
  localparam int RI_DHI  = 1;
  localparam int RI_IEN  = 2;
  localparam int RI_EXT  = 3;
  localparam int RI_LINE = 4;
  localparam int RI_MDM  = 5;
  localparam int RI_MODE = 6;
  localparam int NREG    = 7;

  typedef enum logic [1:0] {
    BANK_OPER = 2'd0,
    BANK_DIV  = 2'd1,
    BANK_EXT  = 2'd2
  } bank_t;

  function automatic bank_t bank_of(input logic [DATA_W-1:0] line);
    if (line == UNLOCK_KEY)  return BANK_EXT;
    else if (line[BANK_BIT]) return BANK_DIV;
    else                     return BANK_OPER;
  endfunction

  function automatic logic [DATA_W-1:0] reg_rst(input int idx);
    return (idx == RI_MODE) ? 8'h07 : 8'h00;
  endfunction

  function automatic logic mode_is_off(input logic [MODE_W-1:0] m);
    return &m;
  endfunction

endpackage

// File: rtl/uart_cfg_reg.sv
module uart_cfg_reg #(
  parameter int                W   = 8,
  parameter logic [W-1:0]      RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST;
    else if (clr) q <= RST;
    else if (we)  q <= d;
  end
endmodule

// File: rtl/uart_cfg_srst.sv
module uart_cfg_srst #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/uart_cfg_decode.sv
module uart_cfg_decode
  import uart_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] line,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              guard_open,
  output bank_t             bank,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel,
  output logic              wr_syscfg,
  output logic              rd_sysstat
);
  logic [NREG-1:0] hit;
  logic            hit_cfg;
  logic            hit_stat;
  logic [NREG-1:0] guard_mask;

  always_comb begin
    bank     = bank_of(line);
    hit      = '0;
    hit_cfg  = 1'b0;
    hit_stat = 1'b0;
    case (addr)
      A_LOW:     if (bank == BANK_DIV) hit[RI_DLO] = 1'b1;
      A_HIGH: begin
        if (bank == BANK_DIV)       hit[RI_DHI] = 1'b1;
        else if (bank == BANK_OPER) hit[RI_IEN] = 1'b1;
      end
      A_EXT:     if (bank == BANK_EXT)  hit[RI_EXT] = 1'b1;
      A_LINE:    hit[RI_LINE] = 1'b1;
      A_MODEM:   if (bank == BANK_OPER) hit[RI_MDM] = 1'b1;
      A_MODE:    hit[RI_MODE] = 1'b1;
      A_SYSCFG:  hit_cfg  = 1'b1;
      default:   hit_stat = 1'b1;
    endcase
  end

  always_comb begin
    guard_mask = '1;
    if (!guard_open) begin
      guard_mask[RI_IEN] = 1'b0;
      guard_mask[RI_MDM] = 1'b0;
    end
  end

  assign wr_sel     = (wr_en && !busy) ? (hit & guard_mask) : '0;
  assign rd_sel     = rd_en ? hit : '0;
  assign wr_syscfg  = wr_en && !busy && hit_cfg;
  assign rd_sysstat = rd_en && hit_stat;
endmodule

// File: rtl/uart_cfg_regbank.sv
module uart_cfg_regbank
  import uart_cfg_pkg::*;
#(
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        lcr_o,
  output logic [7:0]        ier_o,
  output logic [7:0]        mcr_o,
  output logic [15:0]       divisor_o,
  output logic              break_o,
  output logic              enh_en_o,
  output logic [2:0]        mode_o,
  output logic              uart_disabled_o,
  output logic              srst_busy_o
);
  logic [DATA_W-1:0] q [NREG];
  logic [NREG-1:0]   wr_sel;
  logic [NREG-1:0]   rd_sel;
  logic              wr_syscfg;
  logic              rd_sysstat;
  bank_t             bank;

  // named events for the checker
  logic              srst_start;
  logic              srst_clear;

  uart_cfg_decode u_dec (
    .addr       (addr_i),
    .line       (q[RI_LINE]),
    .wr_en      (wr_en_i),
    .rd_en      (rd_en_i),
    .busy       (srst_busy_o),
    .guard_open (q[RI_EXT][GUARD_BIT]),
    .bank       (bank),
    .wr_sel     (wr_sel),
    .rd_sel     (rd_sel),
    .wr_syscfg  (wr_syscfg),
    .rd_sysstat (rd_sysstat)
  );

  assign srst_start = wr_syscfg && wdata_i[SRST_BIT];
  assign srst_clear = srst_busy_o;

  uart_cfg_srst #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy_o)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    uart_cfg_reg #(.W(DATA_W), .RST(reg_rst(g))) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (srst_clear),
      .we    (wr_sel[g]),
      .d     (wdata_i),
      .q     (q[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel[i]) rdata_o = rdata_o | q[i];
    end
    if (rd_sysstat) rdata_o = {{(DATA_W-1){1'b0}}, ~srst_busy_o};
  end

  assign lcr_o           = q[RI_LINE];
  assign ier_o           = q[RI_IEN];
  assign mcr_o           = q[RI_MDM];
  assign divisor_o       = {q[RI_DHI], q[RI_DLO]};
  assign break_o         = q[RI_LINE][BREAK_BIT];
  assign enh_en_o        = q[RI_EXT][GUARD_BIT];
  assign mode_o          = q[RI_MODE][MODE_W-1:0];
  assign uart_disabled_o = mode_is_off(q[RI_MODE][MODE_W-1:0]);
endmodule

// File: rtl/uart_cfg_regbank_chk.sv
module uart_cfg_regbank_chk #(
  parameter int SRST_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [7:0]  rdata_o,
  input logic [7:0]  lcr_o,
  input logic [7:0]  ier_o,
  input logic [7:0]  mcr_o,
  input logic [15:0] divisor_o,
  input logic        enh_en_o,
  input logic        uart_disabled_o,
  input logic        srst_busy_o,
  input logic        srst_start
);
  logic [31:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bcnt <= '0;
    else if (srst_busy_o) bcnt <= bcnt + 1;
    else                  bcnt <= '0;
  end

  a_r4_ier_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_o != $past(ier_o)) |-> ($past(srst_busy_o) ||
      $past(wr_en_i && addr_i == 3'd1 && !lcr_o[7] && enh_en_o)));

  a_r4_mcr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_o != $past(mcr_o)) |-> ($past(srst_busy_o) ||
      $past(wr_en_i && addr_i == 3'd4 && !lcr_o[7] && enh_en_o)));

  a_r2_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en_o != $past(enh_en_o)) |-> ($past(srst_busy_o) ||
      $past(wr_en_i && addr_i == 3'd2 && lcr_o == 8'hBF)));

  a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_busy_o) |-> $past(srst_start && wr_en_i && addr_i == 3'd6 && wdata_i[1]));

  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy_o |-> (bcnt < SRST_CYCLES));

  a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy_o) |-> (bcnt == SRST_CYCLES));

  a_r8_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == 3'd7 && srst_busy_o) |-> (rdata_o[0] == 1'b0));

  a_r9_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_busy_o) |-> (ier_o == 8'h00 && mcr_o == 8'h00 && lcr_o == 8'h00 &&
                            divisor_o == 16'h0000 && uart_disabled_o));

  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (rdata_o == 8'h00));
endmodule

bind uart_cfg_regbank uart_cfg_regbank_chk #(.SRST_CYCLES(SRST_CYCLES)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .wr_en_i         (wr_en_i),
  .rd_en_i         (rd_en_i),
  .rdata_o         (rdata_o),
  .lcr_o           (lcr_o),
  .ier_o           (ier_o),
  .mcr_o           (mcr_o),
  .divisor_o       (divisor_o),
  .enh_en_o        (enh_en_o),
  .uart_disabled_o (uart_disabled_o),
  .srst_busy_o     (srst_busy_o),
  .srst_start      (srst_start)
);

// File: tb/uart_cfg_regbank_tb.sv
module uart_cfg_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rdata_o, lcr_o, ier_o, mcr_o;
  logic [15:0] divisor_o;
  logic        break_o, enh_en_o, uart_disabled_o, srst_busy_o;
  logic [2:0]  mode_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_cfg_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .lcr_o(lcr_o), .ier_o(ier_o), .mcr_o(mcr_o), .divisor_o(divisor_o),
    .break_o(break_o), .enh_en_o(enh_en_o), .mode_o(mode_o),
    .uart_disabled_o(uart_disabled_o), .srst_busy_o(srst_busy_o)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] a;
    logic [7:0] d;
    logic [3:0] req;
  } vec_t;

  // wr=1: write d; wr=0: read and expect d
  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd3, 8'h00, 4'd1},   // R1 line
    '{1'b0, 3'd5, 8'h07, 4'd1},   // R1 mode
    '{1'b0, 3'd7, 8'h01, 4'd1},   // R1 status
    '{1'b1, 3'd1, 8'h0F, 4'd4},   // R4 guard closed
    '{1'b0, 3'd1, 8'h00, 4'd4},
    '{1'b1, 3'd3, 8'hBF, 4'd2},   // R2 unlock
    '{1'b0, 3'd2, 8'h00, 4'd2},
    '{1'b1, 3'd2, 8'h10, 4'd2},
    '{1'b0, 3'd2, 8'h10, 4'd2},
    '{1'b0, 3'd1, 8'h00, 4'd3},   // R3 hidden in ext bank
    '{1'b1, 3'd3, 8'h03, 4'd3},
    '{1'b0, 3'd2, 8'h00, 4'd2},   // R2 locked
    '{1'b1, 3'd2, 8'hFF, 4'd2},
    '{1'b1, 3'd1, 8'h0F, 4'd4},   // R4 guard open
    '{1'b0, 3'd1, 8'h0F, 4'd4},
    '{1'b1, 3'd4, 8'h0B, 4'd4},
    '{1'b0, 3'd4, 8'h0B, 4'd3},
    '{1'b1, 3'd3, 8'h83, 4'd5},   // R5 divisor bank
    '{1'b1, 3'd0, 8'h34, 4'd5},
    '{1'b1, 3'd1, 8'h12, 4'd5},
    '{1'b0, 3'd0, 8'h34, 4'd5},
    '{1'b0, 3'd1, 8'h12, 4'd5},
    '{1'b0, 3'd4, 8'h00, 4'd3},   // R3 modem hidden
    '{1'b1, 3'd4, 8'h55, 4'd3},
    '{1'b1, 3'd3, 8'h43, 4'd6},
    '{1'b0, 3'd4, 8'h0B, 4'd3},
    '{1'b0, 3'd1, 8'h0F, 4'd3},
    '{1'b0, 3'd0, 8'h00, 4'd5},
    '{1'b1, 3'd3, 8'hBF, 4'd2},
    '{1'b0, 3'd2, 8'h10, 4'd2},   // R2 earlier write dropped
    '{1'b0, 3'd3, 8'hBF, 4'd10},  // R10 line always visible
    '{1'b0, 3'd6, 8'h00, 4'd8}    // R8 config reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive at falling edge; reads sampled 1 ns later, writes land at next rising edge
  task automatic bus(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus(1'b1, 1'b0, a, d);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    bus(1'b0, 1'b1, a, 8'h00);
    chk(req, rdata_o, exp);
  endtask

  task automatic idle();
    bus(1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 output defaults
    chk("R1 ier", ier_o, 8'h00);
    chk("R1 mcr", mcr_o, 8'h00);
    chk("R1 div", divisor_o, 16'h0000);
    chk("R1 dis", uart_disabled_o, 1'b1);
    chk("R1 busy", srst_busy_o, 1'b0);
    chk("R1 enh", enh_en_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].wr, !VEC[i].wr, VEC[i].a, VEC[i].wr ? VEC[i].d : 8'h00);
      if (!VEC[i].wr) chk($sformatf("R%0d vec%0d", VEC[i].req, i), rdata_o, VEC[i].d);
    end

    // R6 break follows line bit 6
    wr(3'd3, 8'h40); idle();
    chk("R6 break set", break_o, 1'b1);
    chk("R5 divisor out", divisor_o, 16'h1234);
    wr(3'd3, 8'h00); idle();
    chk("R6 break clear", break_o, 1'b0);

    // R7 mode field
    wr(3'd5, 8'h05); idle();
    chk("R7 mode", mode_o, 3'd5);
    chk("R7 enabled", uart_disabled_o, 1'b0);
    wr(3'd5, 8'hAF); idle();
    chk("R7 off low bits", uart_disabled_o, 1'b1);
    wr(3'd5, 8'h02); idle();
    chk("R7 mode2", uart_disabled_o, 1'b0);

    // R8/R9 soft reset with a write during it
    wr(3'd6, 8'h02);                 // request lands at edge 0
    rd_chk("R8 status busy e0", 3'd7, 8'h00);
    chk("R8 busy out", srst_busy_o, 1'b1);
    wr(3'd1, 8'hAA);                 // collides with the clear
    rd_chk("R8 status busy e2", 3'd7, 8'h00);
    rd_chk("R8 status busy e3", 3'd7, 8'h00);
    rd_chk("R8 status done e4", 3'd7, 8'h01);
    chk("R8 busy cleared", srst_busy_o, 1'b0);
    rd_chk("R8 cfg reads zero", 3'd6, 8'h00);
    chk("R9 ier", ier_o, 8'h00);
    chk("R9 mcr", mcr_o, 8'h00);
    chk("R9 line", lcr_o, 8'h00);
    chk("R9 div", divisor_o, 16'h0000);
    chk("R9 enh", enh_en_o, 1'b0);
    chk("R9 mode", mode_o, 3'd7);
    chk("R9 disabled", uart_disabled_o, 1'b1);

    // R9 writes resume; R4 path again
    wr(3'd3, 8'hBF); wr(3'd2, 8'h10); wr(3'd3, 8'h00); wr(3'd1, 8'h05); idle();
    chk("R9 writes resume", ier_o, 8'h05);

    // R10 idle read returns zero
    bus(1'b0, 1'b0, 3'd5, 8'h00);
    chk("R10 idle rdata", rdata_o, 8'h00);
    rd_chk("R10 mode visible", 3'd5, 8'h07);

    idle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule